// File: doc/BRIEF.md
# Instruction Translation Buffer with Selective Invalidation

This block is a small, fully associative translation buffer for instruction fetch. Each slot holds a virtual page tag, the address space number (ASN) it was loaded under, a global flag, a two-bit granularity hint, one read-permission bit for each of four privilege modes, and a physical frame number. Software loads a slot in two steps. It first writes the virtual page into a tag holding register, then writes a page-table word. That second write fills the slot at a round-robin allocation pointer.

A fetch address and the current ASN are translated combinationally. The result is a hit flag, the physical frame, and the permission bit for the current mode. Three invalidation commands exist, and they affect only the buffer's own slots: flush everything, flush every slot that is not global, and flush one page. The single-page flush honours each slot's granularity hint and its ASN or global flag.

Top module: `ifetch_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses. The allocation pointer starts at slot 0.
- R2: A write on `pte_wr_en` fills the slot at the allocation pointer and marks it valid. The slot takes the page held by the last `tag_wr_en` write and the ASN on `cur_asn` at that time. The page-table word is packed as frame [37:7], read enables [6:3] (bit 3 kernel, 4 executive, 5 supervisor, 6 user), global flag [2] and granularity hint [1:0]. The pointer then steps by one and wraps from NUM_ENT-1 to 0, so the (NUM_ENT+1)-th load replaces the first one.
- R3: A lookup hits when a valid slot matches the masked page and either its ASN equals `cur_asn` or its global flag is set.
- R4: On a hit, `lk_pfn` is the stored frame with its masked low bits taken from the low bits of `lk_vpn`. `lk_rd_ok` is the read enable selected by `cur_mode` (0 kernel, 1 executive, 2 supervisor, 3 user). On a miss, `lk_pfn` and `lk_rd_ok` are 0.
- R5: Granularity hint values 0, 1, 2 and 3 ignore the low 0, 3, 6 and 9 page bits respectively. This applies both in lookup and in single-page invalidation.
- R6: `inv_all` clears every slot and returns the allocation pointer to slot 0.
- R7: `inv_proc` clears every slot whose global flag is 0. Global slots survive.
- R8: `inv_one` clears each slot whose masked page equals `inv_vpn` and whose ASN equals `cur_asn` or whose global flag is set. It leaves every other slot untouched.
- R9: A lookup in the same cycle as any invalidation sees the contents from before that invalidation. A load in the same cycle as `inv_all` is dropped. A load in the same cycle as `inv_proc` survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_wr_en | input | 1 | Load the tag holding register |
| tag_wr_vpn | input | 35 | Virtual page number for the next load |
| pte_wr_en | input | 1 | Page-table word write; allocates a slot |
| pte_wr_data | input | 38 | Page-table word (layout in R2) |
| cur_asn | input | 8 | Current address space number |
| cur_mode | input | 2 | Current privilege mode |
| inv_all | input | 1 | Flush all slots |
| inv_proc | input | 1 | Flush non-global slots |
| inv_one | input | 1 | Flush one page |
| inv_vpn | input | 35 | Page for the single-page flush |
| lk_vpn | input | 35 | Fetch virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 31 | Translated physical frame |
| lk_rd_ok | output | 1 | Read allowed in the current mode |

## Verification
A lookup and an invalidation can fall in the same cycle. So can a load and a flush. The bench drives a single-page flush together with a lookup of that same page. It checks that the lookup still hits before the clock edge and misses after it. It also issues the page-table write in the very cycle of `inv_proc` and checks that the new slot survives. Finally it issues the page-table write in the very cycle of `inv_all` and checks that the load is dropped.

// File: rtl/ifetch_tlb_pkg.sv
package ifetch_tlb_pkg;
   typedef enum logic [1:0] {
      MODE_KERN = 2'd0,
      MODE_EXEC = 2'd1,
      MODE_SUPV = 2'd2,
      MODE_USER = 2'd3
   } fetch_mode_e;

   // number of low page bits ignored for a given hint
   function automatic int unsigned gh_drop(input logic [1:0] gh, input int unsigned step);
      return int'(gh) * step;
   endfunction
endpackage

// File: rtl/ifetch_tlb_entry.sv
module ifetch_tlb_entry #(
   parameter int unsigned VPN_W   = 35,
   parameter int unsigned PFN_W   = 31,
   parameter int unsigned ASN_W   = 8,
   parameter int unsigned GH_STEP = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             inv_all_i,
   input  logic             inv_proc_i,
   input  logic             inv_one_i,
   input  logic [VPN_W-1:0] inv_vpn_i,
   input  logic [ASN_W-1:0] cur_asn_i,
   input  logic [VPN_W-1:0] new_vpn_i,
   input  logic             new_glob_i,
   input  logic [1:0]       new_gh_i,
   input  logic [3:0]       new_re_i,
   input  logic [PFN_W-1:0] new_pfn_i,
   input  logic [VPN_W-1:0] lk_vpn_i,
   output logic             valid_o,
   output logic             lk_match_o,
   output logic [1:0]       gh_o,
   output logic [3:0]       re_o,
   output logic [PFN_W-1:0] pfn_o
);
   import ifetch_tlb_pkg::*;

   logic             valid_q;
   logic [VPN_W-1:0] vpn_q;
   logic [ASN_W-1:0] asn_q;
   logic             glob_q;
   logic [1:0]       gh_q;
   logic [3:0]       re_q;
   logic [PFN_W-1:0] pfn_q;

   logic [VPN_W-1:0] keep_m;
   logic             owner_ok;
   logic             inv_hit;

   always_comb begin
      keep_m     = {VPN_W{1'b1}} << gh_drop(gh_q, GH_STEP);
      owner_ok   = glob_q || (asn_q == cur_asn_i);
      lk_match_o = valid_q && owner_ok && ((lk_vpn_i & keep_m) == (vpn_q & keep_m));
      inv_hit    = inv_one_i && owner_ok && ((inv_vpn_i & keep_m) == (vpn_q & keep_m));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         vpn_q   <= '0;
         asn_q   <= '0;
         glob_q  <= 1'b0;
         gh_q    <= '0;
         re_q    <= '0;
         pfn_q   <= '0;
      end else if (inv_all_i) begin
         valid_q <= 1'b0;
      end else if (wr_i) begin
         valid_q <= 1'b1;
         vpn_q   <= new_vpn_i;
         asn_q   <= cur_asn_i;
         glob_q  <= new_glob_i;
         gh_q    <= new_gh_i;
         re_q    <= new_re_i;
         pfn_q   <= new_pfn_i;
      end else if ((inv_proc_i && !glob_q) || inv_hit) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign gh_o    = gh_q;
   assign re_o    = re_q;
   assign pfn_o   = pfn_q;

   assert_all_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all_i |=> !valid_q);
   assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !inv_all_i) |=> valid_q);
   assert_proc_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_proc_i && !wr_i && !glob_q) |=> !valid_q);
   assert_proc_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_proc_i && !inv_one_i && !inv_all_i && valid_q && glob_q) |=> valid_q);
endmodule

// File: rtl/ifetch_tlb_alloc.sv
module ifetch_tlb_alloc #(
   parameter int unsigned NUM_ENT = 16,
   localparam int unsigned PTR_W  = $clog2(NUM_ENT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_i,
   input  logic               clr_i,
   output logic [NUM_ENT-1:0] wr_sel_o
);
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_nx;

   assign ptr_nx = (ptr_q == PTR_W'(NUM_ENT - 1)) ? '0 : ptr_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (clr_i)   ptr_q <= '0;
      else if (alloc_i) ptr_q <= ptr_nx;
   end

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_dec
      assign wr_sel_o[i] = alloc_i && !clr_i && (ptr_q == PTR_W'(i));
   end

   assert_ptr_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (ptr_q == '0));
   assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_i && !clr_i) |=>
         (ptr_q == (($past(ptr_q) == PTR_W'(NUM_ENT - 1)) ? '0 : $past(ptr_q) + 1'b1)));
   assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_i && !clr_i) |=> $stable(ptr_q));
endmodule

// File: rtl/ifetch_tlb_hitsel.sv
module ifetch_tlb_hitsel #(
   parameter int unsigned NUM_ENT       = 16,
   parameter bit          PRIORITY_PICK = 1'b1
) (
   input  logic [NUM_ENT-1:0] match_i,
   output logic [NUM_ENT-1:0] sel_o,
   output logic               hit_o
);
   assign hit_o = |match_i;

   if (PRIORITY_PICK) begin : g_prio
      always_comb begin
         logic found;
         found = 1'b0;
         sel_o = '0;
         for (int i = 0; i < NUM_ENT; i++) begin
            if (match_i[i] && !found) begin
               sel_o[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end else begin : g_flat
      assign sel_o = match_i;
   end
endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb #(
   parameter int unsigned NUM_ENT       = 16,
   parameter int unsigned VPN_W         = 35,
   parameter int unsigned PFN_W         = 31,
   parameter int unsigned ASN_W         = 8,
   parameter int unsigned GH_STEP       = 3,
   parameter bit          PRIORITY_PICK = 1'b1,
   localparam int unsigned PTE_W        = PFN_W + 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tag_wr_en,
   input  logic [VPN_W-1:0] tag_wr_vpn,
   input  logic             pte_wr_en,
   input  logic [PTE_W-1:0] pte_wr_data,
   input  logic [ASN_W-1:0] cur_asn,
   input  logic [1:0]       cur_mode,
   input  logic             inv_all,
   input  logic             inv_proc,
   input  logic             inv_one,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_rd_ok
);
   import ifetch_tlb_pkg::*;

   localparam int unsigned PFN_LSB = 7;
   localparam int unsigned RE_LSB  = 3;
   localparam int unsigned GLB_BIT = 2;

   if (NUM_ENT < 2) begin : g_bad_ent
      $fatal(1, "NUM_ENT must be at least 2");
   end
   if (3 * GH_STEP >= PFN_W || PFN_W > VPN_W) begin : g_bad_w
      $fatal(1, "granularity span must fit inside the frame and page widths");
   end

   logic [VPN_W-1:0]   tag_q;
   logic [NUM_ENT-1:0] wr_sel, match_v, sel_v, valid_v;
   logic [1:0]         gh_a  [NUM_ENT];
   logic [3:0]         re_a  [NUM_ENT];
   logic [PFN_W-1:0]   pfn_a [NUM_ENT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tag_q <= '0;
      else if (tag_wr_en) tag_q <= tag_wr_vpn;
   end

   ifetch_tlb_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
      .clk(clk), .rst_n(rst_n), .alloc_i(pte_wr_en), .clr_i(inv_all), .wr_sel_o(wr_sel)
   );

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      ifetch_tlb_entry #(
         .VPN_W(VPN_W), .PFN_W(PFN_W), .ASN_W(ASN_W), .GH_STEP(GH_STEP)
      ) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_i       (wr_sel[i]),
         .inv_all_i  (inv_all),
         .inv_proc_i (inv_proc),
         .inv_one_i  (inv_one),
         .inv_vpn_i  (inv_vpn),
         .cur_asn_i  (cur_asn),
         .new_vpn_i  (tag_q),
         .new_glob_i (pte_wr_data[GLB_BIT]),
         .new_gh_i   (pte_wr_data[1:0]),
         .new_re_i   (pte_wr_data[RE_LSB +: 4]),
         .new_pfn_i  (pte_wr_data[PFN_LSB +: PFN_W]),
         .lk_vpn_i   (lk_vpn),
         .valid_o    (valid_v[i]),
         .lk_match_o (match_v[i]),
         .gh_o       (gh_a[i]),
         .re_o       (re_a[i]),
         .pfn_o      (pfn_a[i])
      );
   end

   ifetch_tlb_hitsel #(.NUM_ENT(NUM_ENT), .PRIORITY_PICK(PRIORITY_PICK)) u_sel (
      .match_i(match_v), .sel_o(sel_v), .hit_o(lk_hit)
   );

   logic [1:0]       sel_gh;
   logic [3:0]       sel_re;
   logic [PFN_W-1:0] sel_pfn, pmask;

   always_comb begin
      sel_gh  = '0;
      sel_re  = '0;
      sel_pfn = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         sel_gh  = sel_gh  | ({2{sel_v[i]}} & gh_a[i]);
         sel_re  = sel_re  | ({4{sel_v[i]}} & re_a[i]);
         sel_pfn = sel_pfn | ({PFN_W{sel_v[i]}} & pfn_a[i]);
      end
      pmask    = {PFN_W{1'b1}} << gh_drop(sel_gh, GH_STEP);
      lk_pfn   = lk_hit ? ((sel_pfn & pmask) | (lk_vpn[PFN_W-1:0] & ~pmask)) : '0;
      lk_rd_ok = lk_hit && sel_re[cur_mode];
   end

   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));
   assert_hit_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (valid_v != '0));
   assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pfn == '0 && !lk_rd_ok));
   assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (valid_v == '0));
endmodule

// File: tb/ifetch_tlb_tb.sv
module ifetch_tlb_tb;
   localparam int CLK_P   = 10;
   localparam int NUM_ENT = 16;

   typedef struct packed {
      logic [34:0] vpn;
      logic [7:0]  asn;
      logic [1:0]  mode;
      logic        hit;
      logic [30:0] pfn;
      logic        rd;
   } lk_vec_t;

   localparam lk_vec_t LK_TAB [12] = '{
      '{35'h100,   8'd5,  2'd0, 1'b1, 31'h1000,  1'b1},
      '{35'h100,   8'd5,  2'd3, 1'b1, 31'h1000,  1'b0},
      '{35'h100,   8'd6,  2'd0, 1'b0, 31'h0,     1'b0},
      '{35'h101,   8'd5,  2'd0, 1'b0, 31'h0,     1'b0},
      '{35'h20B,   8'd99, 2'd2, 1'b1, 31'h2003,  1'b1},
      '{35'h210,   8'd5,  2'd0, 1'b0, 31'h0,     1'b0},
      '{35'h402A,  8'd7,  2'd3, 1'b1, 31'h302A,  1'b1},
      '{35'h4040,  8'd7,  2'd3, 1'b0, 31'h0,     1'b0},
      '{35'h801FF, 8'd7,  2'd2, 1'b1, 31'h401FF, 1'b1},
      '{35'h801FF, 8'd7,  2'd1, 1'b1, 31'h401FF, 1'b0},
      '{35'h300,   8'd9,  2'd1, 1'b1, 31'h5555,  1'b1},
      '{35'h300,   8'd5,  2'd1, 1'b0, 31'h0,     1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tag_wr_en = 1'b0, pte_wr_en = 1'b0;
   logic [34:0] tag_wr_vpn = '0, inv_vpn = '0, lk_vpn = '0;
   logic [37:0] pte_wr_data = '0;
   logic [7:0]  cur_asn = '0;
   logic [1:0]  cur_mode = '0;
   logic        inv_all = 1'b0, inv_proc = 1'b0, inv_one = 1'b0;
   logic        lk_hit, lk_rd_ok;
   logic [30:0] lk_pfn;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   ifetch_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .tag_wr_en(tag_wr_en), .tag_wr_vpn(tag_wr_vpn),
      .pte_wr_en(pte_wr_en), .pte_wr_data(pte_wr_data), .cur_asn(cur_asn),
      .cur_mode(cur_mode), .inv_all(inv_all), .inv_proc(inv_proc), .inv_one(inv_one),
      .inv_vpn(inv_vpn), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
      .lk_rd_ok(lk_rd_ok)
   );

   // page-table word: frame [37:7], enables [6:3], global [2], hint [1:0]
   function automatic logic [37:0] mk_pte(input logic [30:0] pfn, input logic [3:0] re,
                                          input logic glob, input logic [1:0] gh);
      return {pfn, re, glob, gh};
   endfunction

   task automatic check(input string rq, input logic [32:0] act, input logic [32:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got hit/rd/pfn %h expected %h", rq, act, exp);
      end
   endtask

   // drive a lookup now, sample 1 time unit later
   task automatic probe(input string rq, input logic [34:0] v, input logic [7:0] a,
                        input logic [1:0] m, input logic eh, input logic [30:0] ep,
                        input logic er);
      lk_vpn = v; cur_asn = a; cur_mode = m;
      #1;
      check(rq, {lk_hit, lk_rd_ok, lk_pfn}, {eh, er, ep});
   endtask

   task automatic look(input string rq, input logic [34:0] v, input logic [7:0] a,
                       input logic [1:0] m, input logic eh, input logic [30:0] ep,
                       input logic er);
      @(negedge clk);
      probe(rq, v, a, m, eh, ep, er);
   endtask

   task automatic load(input logic [34:0] v, input logic [7:0] a, input logic [37:0] d);
      @(negedge clk);
      tag_wr_en = 1'b1; tag_wr_vpn = v;
      @(negedge clk);
      tag_wr_en = 1'b0; pte_wr_en = 1'b1; pte_wr_data = d; cur_asn = a;
      @(negedge clk);
      pte_wr_en = 1'b0;
   endtask

   task automatic kill_one(input logic [34:0] v, input logic [7:0] a);
      @(negedge clk);
      inv_one = 1'b1; inv_vpn = v; cur_asn = a;
      @(negedge clk);
      inv_one = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: nothing valid right after reset
      probe("R1", 35'h0, 8'd0, 2'd0, 1'b0, 31'h0, 1'b0);
      probe("R1", 35'h100, 8'd5, 2'd0, 1'b0, 31'h0, 1'b0);
      rst_n = 1'b1;
      look("R1", 35'h100, 8'd5, 2'd0, 1'b0, 31'h0, 1'b0);

      // R2 loads with hints 0..3 (R5)
      load(35'h100,   8'd5, mk_pte(31'h1000,  4'b0001, 1'b0, 2'd0));
      load(35'h208,   8'd5, mk_pte(31'h2000,  4'b1111, 1'b1, 2'd1));
      load(35'h4000,  8'd7, mk_pte(31'h3000,  4'b1000, 1'b0, 2'd2));
      load(35'h80000, 8'd7, mk_pte(31'h40000, 4'b0100, 1'b0, 2'd3));
      load(35'h300,   8'd9, mk_pte(31'h5555,  4'b0010, 1'b0, 2'd0));

      // table walk: R2 R3 R4 R5
      foreach (LK_TAB[i]) begin
         look($sformatf("R3/R4/R5 vec%0d", i), LK_TAB[i].vpn, LK_TAB[i].asn,
              LK_TAB[i].mode, LK_TAB[i].hit, LK_TAB[i].pfn, LK_TAB[i].rd);
      end

      // R8: wrong ASN, non-global slot is untouched
      kill_one(35'h100, 8'd6);
      look("R8", 35'h100, 8'd5, 2'd0, 1'b1, 31'h1000, 1'b1);
      // R8 R5: global slot, hint-masked page match
      kill_one(35'h20D, 8'd0);
      look("R8", 35'h20B, 8'd5, 2'd2, 1'b0, 31'h0, 1'b0);
      kill_one(35'h4015, 8'd7);
      look("R5", 35'h402A, 8'd7, 2'd3, 1'b0, 31'h0, 1'b0);
      look("R8", 35'h801FF, 8'd7, 2'd2, 1'b1, 31'h401FF, 1'b1);

      // R9: lookup in the cycle of a single-page flush sees old state
      @(negedge clk);
      inv_one = 1'b1; inv_vpn = 35'h100;
      probe("R9", 35'h100, 8'd5, 2'd0, 1'b1, 31'h1000, 1'b1);
      @(negedge clk);
      inv_one = 1'b0;
      probe("R8", 35'h100, 8'd5, 2'd0, 1'b0, 31'h0, 1'b0);

      // R7: non-global flush
      load(35'h600, 8'd3, mk_pte(31'h6000, 4'b1111, 1'b1, 2'd0));
      load(35'h700, 8'd3, mk_pte(31'h7000, 4'b1111, 1'b0, 2'd0));
      @(negedge clk); inv_proc = 1'b1;
      @(negedge clk); inv_proc = 1'b0;
      look("R7", 35'h600, 8'd0, 2'd0, 1'b1, 31'h6000, 1'b1);
      look("R7", 35'h700, 8'd3, 2'd0, 1'b0, 31'h0, 1'b0);
      look("R7", 35'h801FF, 8'd7, 2'd2, 1'b0, 31'h0, 1'b0);
      look("R7", 35'h300, 8'd9, 2'd1, 1'b0, 31'h0, 1'b0);

      // R9: load in the cycle of inv_proc survives
      @(negedge clk); tag_wr_en = 1'b1; tag_wr_vpn = 35'h900;
      @(negedge clk); tag_wr_en = 1'b0; pte_wr_en = 1'b1; cur_asn = 8'd3;
      pte_wr_data = mk_pte(31'h9000, 4'b0001, 1'b0, 2'd0); inv_proc = 1'b1;
      @(negedge clk); pte_wr_en = 1'b0; inv_proc = 1'b0;
      look("R9", 35'h900, 8'd3, 2'd0, 1'b1, 31'h9000, 1'b1);

      // R6: flush everything
      @(negedge clk); inv_all = 1'b1;
      @(negedge clk); inv_all = 1'b0;
      look("R6", 35'h600, 8'd0, 2'd0, 1'b0, 31'h0, 1'b0);
      look("R6", 35'h900, 8'd3, 2'd0, 1'b0, 31'h0, 1'b0);

      // R9: load in the cycle of inv_all is dropped
      @(negedge clk); tag_wr_en = 1'b1; tag_wr_vpn = 35'hA00;
      @(negedge clk); tag_wr_en = 1'b0; pte_wr_en = 1'b1; cur_asn = 8'd2;
      pte_wr_data = mk_pte(31'hA000, 4'b1111, 1'b1, 2'd0); inv_all = 1'b1;
      @(negedge clk); pte_wr_en = 1'b0; inv_all = 1'b0;
      look("R9", 35'hA00, 8'd2, 2'd0, 1'b0, 31'h0, 1'b0);

      // R2: round-robin wrap after NUM_ENT+1 loads
      for (int k = 0; k <= NUM_ENT; k++) begin
         load(35'h1000 + 35'(k), 8'd1, mk_pte(31'h100 + 31'(k), 4'b0001, 1'b0, 2'd0));
      end
      look("R2", 35'h1000, 8'd1, 2'd0, 1'b0, 31'h0, 1'b0);
      look("R2", 35'h1001, 8'd1, 2'd0, 1'b1, 31'h101, 1'b1);
      look("R2", 35'h1010, 8'd1, 2'd0, 1'b1, 31'h110, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule